// File: doc/BRIEF.md
# Serial Fourth-Order Sigma-Delta Division Modulator

This block produces the division value for a fractional-N synthesizer loop. On each restart strobe from the loop divider it advances a cascade of four first-order accumulators, each 32 bits wide, by one step. It turns the four overflow carries into a signed correction, adds that correction to a programmed integer division value, and presents the result as the next 8-bit division value with a done flag. The average of the corrections equals the 32-bit fractional word divided by 2^32, so the mean division ratio has a resolution of one part in 2^32. The quantisation noise is pushed to high offset frequencies by the fourth-order noise-shaping network.

The four accumulators sit in a small register file and share a single 33-bit adder. A controller steps through them one per clock, in cascade order, and each stage adds the freshly updated sum of the stage before it. A final combine step forms the correction from the new carries and from delayed carries kept from earlier updates. Only that step changes the delayed carries. A full update takes five clocks from the accepted start to done, well inside a budget of 146 cycles. Between updates the block holds all of its state. The fractional word and the integer value are loaded through a one-register-per-write port.

Controller states: IDLE (waiting; done holds the last result), STEP1 to STEP4 (accumulator 1 to 4 updated through the shared adder), COMBINE (correction formed, next value registered, delayed carries shifted). Transitions: IDLE to STEP1 on start; STEP1 to STEP2 to STEP3 to STEP4 to COMBINE, one per clock with no condition; COMBINE to IDLE. A start seen in any state other than IDLE has no effect.

Top module: `mash4_serial`

## Requirements
- R1: A start sampled high in IDLE launches exactly one update. Stage 1 adds the fractional word to accumulator 1. Stage k (k = 2, 3, 4) adds the just-updated accumulator k-1 to accumulator k. Each addition is modulo 2^32, and its carry c_k is 1 when the sum reaches 2^32.
- R2: The correction is dN = c1 + (c2 - c2') + (c3 - 2c3' + c3'') + (c4 - 3c4' + 3c4'' - c4'''), where a prime marks the carry of the same stage one update earlier, two primes two updates earlier, and three primes three updates earlier. next_n = (N + dN) mod 256.
- R3: dN always lies in -7..+8. delta_n carries it as 5-bit two's complement.
- R4: done falls in the clock after the start is accepted. It rises exactly five clocks after that start edge, with next_n and delta_n valid. It then holds, with next_n and delta_n unchanged, until the next accepted start.
- R5: An update stays busy for no more than 146 cycles (five in practice).
- R6: A start pulse while busy is high is ignored: it neither extends nor repeats the update.
- R7: With the fractional word at zero and all state cleared by reset, every update gives dN = 0 and next_n = N.
- R8: A write with wr_sel = 0 loads wr_data into the fractional word. A write with wr_sel = 1 loads wr_data[7:0] into N. A write in the same clock as an accepted start is used by that update.
- R9: After reset, done = 0, busy = 0, next_n = 0, and all accumulators and delayed carries are zero.
- R10: While idle, the accumulators and delayed carries do not change, so the next update continues the sequence exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the configuration registers |
| wr_sel | input | 1 | 0 = fractional word, 1 = integer N |
| wr_data | input | 32 | Write data |
| start | input | 1 | Restart strobe from the loop divider |
| busy | output | 1 | High while an update is in progress |
| done | output | 1 | Result valid, held until the next accepted start |
| next_n | output | 8 | N plus correction, modulo 256 |
| delta_n | output | 5 | Signed correction, two's complement |

## Verification
The configuration write and the start of an update can land in the same clock. The first adder step then reads the fractional register one edge later. The bench provokes this by raising wr_en with a new fractional word and start on the same edge, and it applies the new word to its reference model for that update. If the result matches the model, the write was taken in time; a stale word shows up as a mismatched dN. A second collision, a start arriving mid-update, is judged by checking that the held result and the next update match a model advanced only once.

// File: rtl/mash4_pkg.sv
package mash4_pkg;
    localparam int FRAC_W  = 32;
    localparam int N_W     = 8;
    localparam int STAGES  = 4;
    localparam int IDX_W   = $clog2(STAGES);
    localparam int DN_W    = 5;
    localparam int BUDGET  = 146;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP1,
        S_STEP2,
        S_STEP3,
        S_STEP4,
        S_COMBINE
    } mash_state_e;
endpackage

// File: rtl/mash4_ctrl.sv
module mash4_ctrl
    import mash4_pkg::*;
#(
    parameter int NSTG   = STAGES,
    parameter int IW     = IDX_W,
    parameter int LIMIT  = BUDGET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          step_en,
    output logic          first_step,
    output logic [IW-1:0] stage_idx,
    output logic          sum_en,
    output logic          busy,
    output logic          done
);
    localparam int CNT_W = $clog2(LIMIT + 2);

    mash_state_e state_q, state_d;
    logic [CNT_W-1:0] busy_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_STEP1;
            S_STEP1:   state_d = S_STEP2;
            S_STEP2:   state_d = S_STEP3;
            S_STEP3:   state_d = S_STEP4;
            S_STEP4:   state_d = S_COMBINE;
            S_COMBINE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        step_en    = 1'b0;
        first_step = 1'b0;
        stage_idx  = '0;
        sum_en     = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_STEP1: begin
                step_en    = 1'b1;
                first_step = 1'b1;
                stage_idx  = IW'(0);
            end
            S_STEP2: begin
                step_en   = 1'b1;
                stage_idx = IW'(1);
            end
            S_STEP3: begin
                step_en   = 1'b1;
                stage_idx = IW'(2);
            end
            S_STEP4: begin
                step_en   = 1'b1;
                stage_idx = IW'(NSTG - 1);
            end
            S_COMBINE: sum_en = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // result-valid flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           done <= 1'b0;
        else if (state_q == S_IDLE && start)  done <= 1'b0;
        else if (state_q == S_COMBINE)        done <= 1'b1;
    end

    // cycle counter used only by the budget check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         busy_cnt <= '0;
        else if (!busy)                     busy_cnt <= '0;
        else if (busy_cnt != {CNT_W{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
    end

    AST_DONE_AFTER_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMBINE) |=> done);                              // R4
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> (!done && state_q == S_STEP1)); // R4
    AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(LIMIT)));                          // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != S_STEP1));                     // R6
endmodule

// File: rtl/mash4_regfile.sv
module mash4_regfile
    import mash4_pkg::*;
#(
    parameter int DEPTH = STAGES,
    parameter int W     = FRAC_W,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data
);
    logic [DEPTH-1:0][W-1:0] mem;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (wr_en && idx == IW'(i))     mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[idx];

    AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));                                      // R10
endmodule

// File: rtl/mash4_alu.sv
module mash4_alu
    import mash4_pkg::*;
#(
    parameter int W = FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         first_step,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] frac,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W-1:0] link_q;
    logic [W-1:0] addend;
    logic [W:0]   wide;

    // stage 1 takes the fractional word; later stages take the sum just written
    assign addend = first_step ? frac : link_q;
    assign wide   = {1'b0, acc_in} + {1'b0, addend};
    assign sum    = wide[W-1:0];
    assign carry  = wide[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       link_q <= '0;
        else if (step_en) link_q <= sum;
    end

    AST_CARRY_MEANS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && carry) |-> (sum < acc_in));                        // R1
endmodule

// File: rtl/mash4_combine.sv
module mash4_combine
    import mash4_pkg::*;
#(
    parameter int NSTG = STAGES,
    parameter int IW   = IDX_W,
    parameter int NW   = N_W,
    parameter int DW   = DN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [IW-1:0]        stage_idx,
    input  logic                 carry_in,
    input  logic                 sum_en,
    input  logic [NW-1:0]        n_int,
    output logic [NW-1:0]        next_n,
    output logic signed [DW-1:0] delta_n
);
    localparam int SW = 8;

    logic [NSTG-1:0] cur;
    logic            c2_d1;
    logic            c3_d1, c3_d2;
    logic            c4_d1, c4_d2, c4_d3;
    logic signed [SW-1:0] dn;
    logic [5:0]      hist;

    assign hist = {c2_d1, c3_d1, c3_d2, c4_d1, c4_d2, c4_d3};

    // carries of the update in progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur <= '0;
        else if (step_en) cur[stage_idx] <= carry_in;
    end

    // noise-cancelling combination of current and delayed carries
    always_comb begin
        dn = $signed({7'd0, cur[0]})
           + $signed({7'd0, cur[1]}) - $signed({7'd0, c2_d1})
           + $signed({7'd0, cur[2]}) - $signed({6'd0, c3_d1, 1'b0})
           + $signed({7'd0, c3_d2})
           + $signed({7'd0, cur[3]}) - $signed({6'd0, c4_d1, c4_d1})
           + $signed({6'd0, c4_d2, c4_d2}) - $signed({7'd0, c4_d3});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0; c3_d2 <= 1'b0;
            c4_d1 <= 1'b0; c4_d2 <= 1'b0; c4_d3 <= 1'b0;
            next_n  <= '0;
            delta_n <= '0;
        end else if (sum_en) begin
            c2_d1 <= cur[1];
            c3_d2 <= c3_d1; c3_d1 <= cur[2];
            c4_d3 <= c4_d2; c4_d2 <= c4_d1; c4_d1 <= cur[3];
            delta_n <= dn[DW-1:0];
            next_n  <= n_int + {{(NW-DW){dn[DW-1]}}, dn[DW-1:0]};
        end
    end

    AST_DN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_en |-> (dn >= -8'sd7 && dn <= 8'sd8));                     // R3
    AST_HISTORY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_en |=> $stable(hist));                                    // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_en |=> ($stable(next_n) && $stable(delta_n)));            // R4
    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_en && cur == '0 && hist == '0) |=> (delta_n == '0));      // R7
endmodule

// File: rtl/mash4_serial.sv
module mash4_serial
    import mash4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [FRAC_W-1:0] wr_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [N_W-1:0]    next_n,
    output logic [DN_W-1:0]   delta_n
);
    logic [FRAC_W-1:0] frac_q;
    logic [N_W-1:0]    nint_q;
    logic              step_en, first_step, sum_en;
    logic [IDX_W-1:0]  stage_idx;
    logic [FRAC_W-1:0] acc_rd, acc_sum;
    logic              carry;
    logic signed [DN_W-1:0] dn_s;

    // configuration write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
            nint_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) nint_q <= wr_data[N_W-1:0];
            else        frac_q <= wr_data;
        end
    end

    mash4_ctrl #(.NSTG(STAGES), .IW(IDX_W), .LIMIT(BUDGET)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .step_en(step_en), .first_step(first_step), .stage_idx(stage_idx),
        .sum_en(sum_en), .busy(busy), .done(done)
    );

    mash4_regfile #(.DEPTH(STAGES), .W(FRAC_W), .IW(IDX_W)) rf_i (
        .clk(clk), .rst_n(rst_n), .idx(stage_idx), .rd_data(acc_rd),
        .wr_en(step_en), .wr_data(acc_sum)
    );

    mash4_alu #(.W(FRAC_W)) alu_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .first_step(first_step),
        .acc_in(acc_rd), .frac(frac_q), .sum(acc_sum), .carry(carry)
    );

    mash4_combine #(.NSTG(STAGES), .IW(IDX_W), .NW(N_W), .DW(DN_W)) comb_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .stage_idx(stage_idx),
        .carry_in(carry), .sum_en(sum_en), .n_int(nint_q),
        .next_n(next_n), .delta_n(dn_s)
    );

    assign delta_n = dn_s;
endmodule

// File: tb/mash4_serial_tb_top.sv
module mash4_serial_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [7:0]  next_n;
    logic [4:0]  delta_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mash4_serial dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .start(start), .busy(busy), .done(done),
        .next_n(next_n), .delta_n(delta_n)
    );

    // reference model state
    logic [31:0] m_acc [4];
    logic [31:0] m_frac;
    logic [7:0]  m_n;
    int          h2, h3a, h3b, h4a, h4b, h4c;
    int          m_dn;
    logic [7:0]  m_next;

    localparam int NV = 6;
    localparam logic [31:0] V_FRAC [NV] = '{32'h8000_0000, 32'h4000_0000,
        32'hFFFF_FFFF, 32'h0000_0001, 32'h1234_5678, 32'hC000_0000};
    localparam logic [7:0]  V_N    [NV] = '{8'd154, 8'd200, 8'd255,
        8'd160, 8'd180, 8'd3};
    localparam int          V_CNT  [NV] = '{24, 24, 40, 16, 40, 24};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_acc[k] = '0;
        m_frac = '0; m_n = '0;
        h2 = 0; h3a = 0; h3b = 0; h4a = 0; h4b = 0; h4c = 0;
    endtask

    task automatic model_step();
        logic [32:0] s;
        logic [31:0] inp;
        int c [4];
        for (int k = 0; k < 4; k++) begin
            inp = (k == 0) ? m_frac : m_acc[k-1];
            s = {1'b0, m_acc[k]} + {1'b0, inp};
            m_acc[k] = s[31:0];
            c[k] = int'(s[32]);
        end
        m_dn = c[0] + (c[1] - h2) + (c[2] - 2*h3a + h3b)
             + (c[3] - 3*h4a + 3*h4b - h4c);
        h2 = c[1];
        h3b = h3a; h3a = c[2];
        h4c = h4b; h4b = h4a; h4a = c[3];
        m_next = 8'(int'(m_n) + m_dn);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_n = d[7:0]; else m_frac = d;
    endtask

    // one update; optionally a fractional write on the start edge (R8)
    task automatic run_update(input bit with_wr, input logic [31:0] wd, input string tag);
        @(negedge clk);
        start = 1'b1;
        if (with_wr) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = wd; m_frac = wd;
        end
        model_step();
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        check(done == 1'b0 && busy == 1'b1, "R4 done clears on start", int'(done), 0);
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R4 done not early", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R4 R5 done after five clocks", int'(done), 1);
        check(next_n == m_next, {tag, " next_n"}, int'(next_n), int'(m_next));
        check($signed(delta_n) == m_dn, {tag, " delta_n"}, int'($signed(delta_n)), m_dn);
        check($signed(delta_n) >= -7 && $signed(delta_n) <= 8, "R3 range",
              int'($signed(delta_n)), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        @(negedge clk);
        // R9 reset state
        check(done == 1'b0, "R9 done after reset", int'(done), 0);
        check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
        check(next_n == 8'd0, "R9 next_n after reset", int'(next_n), 0);

        // R7 zero fractional word
        write_reg(1'b1, 32'd100);
        for (int i = 0; i < 8; i++) begin
            run_update(1'b0, '0, "R7 R2 zero word");
            check(next_n == 8'd100, "R7 next_n equals N", int'(next_n), 100);
        end

        // vector table: R1 R2 R8 over several words and N values
        for (int v = 0; v < NV; v++) begin
            do_reset();
            write_reg(1'b0, V_FRAC[v]);
            write_reg(1'b1, {24'd0, V_N[v]});
            for (int i = 0; i < V_CNT[v]; i++)
                run_update(1'b0, '0, "R1 R2 table");
        end

        // R10 idle gap then continue the sequence
        repeat (20) @(negedge clk);
        check(done == 1'b1 && next_n == m_next, "R10 idle hold", int'(next_n), int'(m_next));
        for (int i = 0; i < 4; i++) run_update(1'b0, '0, "R10 resume");

        // R8 write on the same edge as start
        run_update(1'b1, 32'h9E37_79B9, "R8 same-cycle write");
        for (int i = 0; i < 6; i++) run_update(1'b0, '0, "R8 after write");

        // R6 start while busy
        @(negedge clk);
        start = 1'b1;
        model_step();
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b1 && next_n == m_next, "R6 single result", int'(next_n), int'(m_next));
        repeat (8) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R6 no second update", int'(busy), 0);
        check(next_n == m_next, "R6 result held", int'(next_n), int'(m_next));
        for (int i = 0; i < 4; i++) run_update(1'b0, '0, "R6 sequence intact");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule